// File: doc/BRIEF.md
# FM Read Clock/Data Separator

This block sits behind a read head's pulse detector on a frequency-modulated disk channel. Each input pulse is one clock cycle long and marks one flux reversal. Every bit occupies a pair of cells. The first cell of the pair always carries a pulse. The second cell carries a pulse only when the bit is a one. The separator has to find out which of the two alternating cell phases is the clock phase. It does this while the sector starts with a run of zero bits, because in that run only clock cells carry pulses.

Once locked, the block sends each pulse to one of two outputs. A pulse in a clock cell goes to a clock line and a pulse in a data cell goes to a data line. A downstream controller decodes the bits from these two lines. A clock pulse with no data pulse since the previous clock pulse is a zero. A data pulse is a one.

The nominal cell length is a parameter, given in clock cycles. At 100 MHz, a cell that is half of a 720 kHz period is 69 cycles. A digital window tracker replaces an analog phase-locked loop. Its expected-pulse timer restarts on every accepted clock pulse, so it follows slow changes in disk speed.

Top module: `fm_clock_data_separator`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `rd_clk_o`, `rd_data_o` and `locked_o` are all 0.
- R2: `locked_o` rises on the cycle after the LOCK_COUNT-th (default 16) consecutive input pulse. A pulse counts as consecutive when it arrives between 2·CELL−CELL/4 and 2·CELL+CELL/4 cycles (inclusive) after the pulse before it.
- R3: A pulse outside that spacing, or a gap longer than 2·CELL+CELL/4 cycles, restarts the count of consecutive pulses while unlocked.
- R4: While locked, a pulse that arrives 2·CELL±CELL/4 cycles after the last accepted clock pulse produces a one-cycle `rd_clk_o` pulse on the next cycle. That pulse also restarts the expected-pulse timer.
- R5: While locked, a pulse that arrives CELL±CELL/4 cycles after the last accepted clock pulse produces a one-cycle `rd_data_o` pulse on the next cycle.
- R6: While unlocked, no input pulse produces a pulse on `rd_clk_o` or `rd_data_o`.
- R7: While locked, a pulse outside both windows produces no output. ERR_LIMIT (default 3) such pulses in a row drop `locked_o` on the next cycle. Any accepted pulse clears the run of errors.
- R8: While locked, if no pulse arrives by 2·CELL+CELL/4 cycles after the last accepted clock pulse, `locked_o` falls one cycle after the timer passes that point.
- R9: Clock pulses that each land at an edge of the window stay accepted indefinitely, because the timer restarts on every one of them.
- R10: While `rd_en_i` is 0, `locked_o` is 0 from the next cycle onward and both pulse outputs stay 0. Pulses received in that state do not build up toward lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Read enable; low clears lock and silences outputs |
| pulse_i | input | 1 | One-cycle pulse per detected flux reversal |
| rd_clk_o | output | 1 | Pulse for each clock-cell pulse after lock |
| rd_data_o | output | 1 | Pulse for each data-cell pulse after lock |
| locked_o | output | 1 | Cell phase is locked |

## Verification
Some properties are checked by the assertions on every cycle:
- the two pulse outputs never fire together, and neither fires without lock;
- lock only appears right after an input pulse;
- a disabled read drops lock on the next cycle;
- the timer saturates at its overdue point and restarts to one after an anchor;
- the error run stays below its limit;
- an overdue clock in the locked state always returns the tracker to the hunt.

Other behaviour depends on exact pulse timing, and only the bench scenarios can show it:
- the exact pulse on which lock arrives;
- the inclusive window edges for clock and data;
- a restart of the preamble count after a bad gap;
- tracking of drifted spacing;
- the third consecutive stray pulse dropping lock.

// File: rtl/fmsep_pkg.sv
package fmsep_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } lock_state_e;

endpackage

// File: rtl/fmsep_cell_timer.sv
module fmsep_cell_timer #(
    parameter int CELL_CYCLES = 69
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic anchor_i,
    output logic in_clk_o,
    output logic in_data_o,
    output logic overdue_o
);
    localparam int PERIOD = 2 * CELL_CYCLES;
    localparam int TOL    = CELL_CYCLES / 4;
    localparam int LIMIT  = PERIOD + TOL + 1;
    localparam int CW     = $clog2(LIMIT + 1);

    localparam logic [CW-1:0] CLK_LO_V = CW'(PERIOD - TOL);
    localparam logic [CW-1:0] CLK_HI_V = CW'(PERIOD + TOL);
    localparam logic [CW-1:0] DAT_LO_V = CW'(CELL_CYCLES - TOL);
    localparam logic [CW-1:0] DAT_HI_V = CW'(CELL_CYCLES + TOL);
    localparam logic [CW-1:0] LIMIT_V  = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] count;
        logic          valid;
    } tmr_t;

    tmr_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clear_i) begin
            r_d.count = '0;
            r_d.valid = 1'b0;
        end else if (anchor_i) begin
            r_d.count = CW'(1);
            r_d.valid = 1'b1;
        end else if (r_q.count != LIMIT_V) begin
            r_d.count = r_q.count + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign in_clk_o  = r_q.valid && (r_q.count >= CLK_LO_V) && (r_q.count <= CLK_HI_V);
    assign in_data_o = r_q.valid && (r_q.count >= DAT_LO_V) && (r_q.count <= DAT_HI_V);
    assign overdue_o = r_q.valid && (r_q.count == LIMIT_V);

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.count <= LIMIT_V) else $error("timer beyond limit"); // R8

    AST_ANCHOR_RECENTRES: assert property (@(posedge clk) disable iff (!rst_n)
        (anchor_i && !clear_i) |=> (r_q.count == CW'(1))) else $error("no re-centre"); // R4

endmodule

// File: rtl/fmsep_lock_ctrl.sv
module fmsep_lock_ctrl
    import fmsep_pkg::*;
#(
    parameter int LOCK_COUNT = 16,
    parameter int ERR_LIMIT  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic pulse_i,
    input  logic in_clk_i,
    input  logic in_data_i,
    input  logic overdue_i,
    output logic anchor_o,
    output logic take_clk_o,
    output logic take_data_o,
    output logic locked_o
);
    localparam int RW = $clog2(LOCK_COUNT + 1);
    localparam int EW = $clog2(ERR_LIMIT + 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(LOCK_COUNT - 1);
    localparam logic [EW-1:0] ERR_LAST = EW'(ERR_LIMIT - 1);

    typedef struct packed {
        lock_state_e   state;
        logic [RW-1:0] run;
        logic [EW-1:0] err;
    } ctl_t;

    ctl_t r_q, r_d;

    always_comb begin
        r_d         = r_q;
        anchor_o    = 1'b0;
        take_clk_o  = 1'b0;
        take_data_o = 1'b0;
        if (!en_i) begin
            r_d.state = ST_HUNT;
            r_d.run   = '0;
            r_d.err   = '0;
        end else if (r_q.state == ST_HUNT) begin
            if (pulse_i) begin
                anchor_o = 1'b1;
                if (in_clk_i) begin
                    if (r_q.run == RUN_LAST) begin
                        r_d.state = ST_LOCK;
                        r_d.run   = '0;
                        r_d.err   = '0;
                    end else begin
                        r_d.run = r_q.run + RW'(1);
                    end
                end else begin
                    r_d.run = RW'(1);
                end
            end else if (overdue_i) begin
                r_d.run = '0;
            end
        end else begin
            if (pulse_i) begin
                if (in_clk_i) begin
                    take_clk_o = 1'b1;
                    anchor_o   = 1'b1;
                    r_d.err    = '0;
                end else if (in_data_i) begin
                    take_data_o = 1'b1;
                    r_d.err     = '0;
                end else if (r_q.err == ERR_LAST) begin
                    r_d.state = ST_HUNT;
                    r_d.run   = '0;
                    r_d.err   = '0;
                end else begin
                    r_d.err = r_q.err + EW'(1);
                end
            end else if (overdue_i) begin
                r_d.state = ST_HUNT;
                r_d.run   = '0;
                r_d.err   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_HUNT, run: '0, err: '0};
        else        r_q <= r_d;
    end

    assign locked_o = (r_q.state == ST_LOCK);

    AST_LOCK_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.state == ST_LOCK) |-> $past(pulse_i)) else $error("lock without pulse"); // R2

    AST_ERR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err <= ERR_LAST) else $error("error run overflow"); // R7

    AST_MISSING_CLOCK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_LOCK && overdue_i && !pulse_i) |=> (r_q.state == ST_HUNT))
        else $error("stayed locked past overdue"); // R8

endmodule

// File: rtl/fmsep_steer.sv
module fmsep_steer (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic take_clk_i,
    input  logic take_data_i,
    output logic rd_clk_o,
    output logic rd_data_o
);
    typedef struct packed {
        logic rclk;
        logic rdata;
    } out_t;

    out_t r_q, r_d;

    always_comb begin
        r_d.rclk  = en_i && take_clk_i;
        r_d.rdata = en_i && take_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_clk_o  = r_q.rclk;
    assign rd_data_o = r_q.rdata;

endmodule

// File: rtl/fm_clock_data_separator.sv
module fm_clock_data_separator #(
    parameter int CELL_CYCLES = 69,
    parameter int LOCK_COUNT  = 16,
    parameter int ERR_LIMIT   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en_i,
    input  logic pulse_i,
    output logic rd_clk_o,
    output logic rd_data_o,
    output logic locked_o
);
    logic anchor, in_clk, in_data, overdue, take_clk, take_data;

    fmsep_cell_timer #(.CELL_CYCLES(CELL_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (!rd_en_i),
        .anchor_i  (anchor),
        .in_clk_o  (in_clk),
        .in_data_o (in_data),
        .overdue_o (overdue)
    );

    fmsep_lock_ctrl #(.LOCK_COUNT(LOCK_COUNT), .ERR_LIMIT(ERR_LIMIT)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (rd_en_i),
        .pulse_i     (pulse_i),
        .in_clk_i    (in_clk),
        .in_data_i   (in_data),
        .overdue_i   (overdue),
        .anchor_o    (anchor),
        .take_clk_o  (take_clk),
        .take_data_o (take_data),
        .locked_o    (locked_o)
    );

    fmsep_steer u_steer (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (rd_en_i),
        .take_clk_i  (take_clk),
        .take_data_i (take_data),
        .rd_clk_o    (rd_clk_o),
        .rd_data_o   (rd_data_o)
    );

    AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_clk_o && rd_data_o)) else $error("both outputs high"); // R4

    AST_OUT_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clk_o || rd_data_o) |-> locked_o) else $error("output while unlocked"); // R6

    AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (!locked_o && !rd_clk_o && !rd_data_o)) else $error("active while disabled"); // R10

endmodule

// File: tb/tb_fm_clock_data_separator.sv
module tb_fm_clock_data_separator;
    localparam int CELL  = 69;
    localparam int PER   = 2 * CELL;
    localparam int TOL   = CELL / 4;
    localparam int LOCKN = 16;
    localparam int ERRN  = 3;
    localparam int NV    = 12;
    // offset from last accepted clock pulse; expected: 0 none, 1 clock, 2 data
    localparam int TAB_OFF [NV] = '{CELL, PER, CELL-TOL, PER-TOL, CELL+TOL, PER+TOL,
                                    PER, 60, 100, 140, 30, 70};
    localparam int TAB_EXP [NV] = '{2, 1, 2, 1, 2, 1, 1, 2, 0, 1, 0, 2};

    logic clk = 1'b0, rst_n = 1'b0, rd_en = 1'b0, pulse = 1'b0;
    logic rd_clk, rd_data, locked;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    fm_clock_data_separator #(.CELL_CYCLES(CELL), .LOCK_COUNT(LOCKN), .ERR_LIMIT(ERRN)) dut (
        .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en), .pulse_i(pulse),
        .rd_clk_o(rd_clk), .rd_data_o(rd_data), .locked_o(locked)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // pulse placed s cycles after the previous one; returns one cycle after it
    task automatic space(int s);
        repeat (s - 1) @(negedge clk);
        pulse = 1'b1;
        @(negedge clk);
        pulse = 1'b0;
    endtask

    task automatic preamble(int n);
        for (int k = 0; k < n; k++) space(PER);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset locked", locked, 0);
        check("R1 reset rd_clk", rd_clk, 0);
        check("R1 reset rd_data", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset locked", locked, 0);
        rd_en = 1'b1;
        @(negedge clk);

        // R2 / R6: lock on the sixteenth pulse, silent before
        preamble(LOCKN - 1);
        check("R2 not locked early", locked, 0);
        check("R6 no clock while hunting", rd_clk, 0);
        space(PER);
        check("R2 locked on last pulse", locked, 1);

        // R4 R5 R7: table walk
        begin
            int prev = 0;
            for (int i = 0; i < NV; i++) begin
                space(TAB_OFF[i] - prev);
                check("R4 table rd_clk", rd_clk, (TAB_EXP[i] == 1) ? 1 : 0);
                check("R5 table rd_data", rd_data, (TAB_EXP[i] == 2) ? 1 : 0);
                prev = (TAB_EXP[i] == 1) ? 0 : TAB_OFF[i];
            end
            space(PER - prev);
            check("R7 single errors keep lock", locked, 1);
        end

        // R9: drift at window edges
        for (int k = 0; k < 4; k++) begin
            space(PER + TOL);
            check("R9 late edge accepted", rd_clk, 1);
        end
        for (int k = 0; k < 3; k++) begin
            space(PER - TOL);
            check("R9 early edge accepted", rd_clk, 1);
        end

        // R7: three stray pulses in a row
        space(100);
        check("R7 first stray no output", rd_clk | rd_data, 0);
        check("R7 first stray keeps lock", locked, 1);
        space(5);
        check("R7 second stray keeps lock", locked, 1);
        space(5);
        check("R7 third stray drops lock", locked, 0);

        // R3: bad gap restarts preamble count
        preamble(10);
        space(PER + TOL + 15);
        preamble(LOCKN - 2);
        check("R3 restart delays lock", locked, 0);
        space(PER);
        check("R3 lock after full run", locked, 1);

        // R8: missing clock pulse
        repeat (PER + TOL) @(negedge clk);
        check("R8 still locked at window end", locked, 1);
        @(negedge clk);
        check("R8 missing clock drops lock", locked, 0);

        // R10: read enable
        preamble(LOCKN);
        check("R10 relocked", locked, 1);
        rd_en = 1'b0;
        @(negedge clk);
        check("R10 disable clears lock", locked, 0);
        space(PER);
        check("R10 disabled no clock", rd_clk, 0);
        preamble(LOCKN);
        check("R10 no lock while disabled", locked, 0);
        rd_en = 1'b1;
        @(negedge clk);
        preamble(LOCKN);
        check("R10 lock after re-enable", locked, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule